// File: doc/BRIEF.md
# Stereo Matching Window Buffer

This block takes two raster-ordered grayscale pixel streams, one from each camera of a stereo pair, and stores the three most recent image rows of each in on-chip row memories. From these rows it builds two 3×3 pixel windows. One is a reference window taken from the left image. The other is a candidate window taken from the right image. Both are handed to a matching-cost engine downstream.

For each reference centre, the block produces a sweep of `DISP` candidate positions on consecutive clocks. The right window moves one column to the right on every clock of the sweep. Each move brings in only the new three-pixel column from the row memories. The reference window stays fixed for the whole sweep. Once the last offset has been presented, the reference window steps one column to the right. The right window is then refilled over three clocks from the column that lines up with the new reference centre.

Input is accepted with a valid/ready handshake only while a row is being loaded. Ready is held low during window refills and sweeps.

Top module: `stereo_window_buffer`

## Requirements
- R1: After reset, `inReady` is 1 and `winValid`, `sweepFirst` and `sweepLast` are 0.
- R2: A pixel pair is taken on a clock edge where both `inValid` and `inReady` are 1. Pixels arrive in raster order, `IMG_W` per row and `IMG_H` rows per frame. `inReady` is 0 in every cycle where `winValid` is 1.
- R3: Windows for centre row y are produced only after row y+1 of the same frame has been accepted. Centre rows run from 1 to `IMG_H-2` and centre columns from 1 to `IMG_W-2`, in increasing order. `centerRow` and `centerCol` report the centre.
- R4: `leftWin` holds the left pixel at column `centerCol-1+c` and row `centerRow-1+r` in bits `[(3r+c)*PIX_W +: PIX_W]`. This is row-major order with the top-left pixel in the low bits. It stays fixed for the whole sweep.
- R5: At offset d, `rightWin` holds, in the same layout, the right pixel at column `centerCol+d-1+c` and row `centerRow-1+r`. A column at or beyond `IMG_W` reads as 0 and never wraps.
- R6: A sweep presents offsets 0 to `DISP-1` on consecutive clocks with `winValid` high. `sweepFirst` is 1 exactly at offset 0 and `sweepLast` is 1 exactly at offset `DISP-1`.
- R7: `candInRange` is 1 exactly when the rightmost candidate column, `centerCol+offset+1`, is at most `IMG_W-1`.
- R8: Between two sweeps of the same centre row there are exactly three clocks with `winValid` low, used to refill the right window.
- R9: After row `IMG_H-1` of a frame, the next pixel accepted is row 0 of a new frame. No window is produced until three rows of the new frame have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel pair valid |
| inReady | output | 1 | Block can accept a pixel pair |
| inLeft | input | PIX_W | Left image pixel |
| inRight | input | PIX_W | Right image pixel |
| winValid | output | 1 | Window pair valid this cycle |
| sweepFirst | output | 1 | Offset 0 of a sweep |
| sweepLast | output | 1 | Last offset of a sweep |
| candInRange | output | 1 | Candidate window lies fully inside the image |
| offset | output | DW | Current disparity offset |
| centerCol | output | XW | Column of the reference centre |
| centerRow | output | YW | Row of the reference centre |
| leftWin | output | 9*PIX_W | Reference 3×3 window, row-major |
| rightWin | output | 9*PIX_W | Candidate 3×3 window, row-major |

## Verification
The hardest cases to reach are a sweep that runs off the right edge of the image, and a new frame whose first rows overwrite row memories the previous frame still referred to. Both depend on the rotation of the row memories staying in step across the frame boundary.

The bench uses a narrow image with a short sweep, so that most sweeps cross the right edge. It streams two full frames with pixel values that differ per frame and inserts source-side gaps. Every window of every sweep is then compared against values computed from the pixel formula.

// File: rtl/stereo_win_pkg.sv
package stereo_win_pkg;

  typedef struct packed {
    logic       wrEn;
    logic       shiftLeft;
    logic       shiftRight;
    logic [1:0] wrSlot;
    logic [1:0] botSlot;
  } winStrobe_t;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_RELOAD = 2'd1,
    ST_SWEEP  = 2'd2
  } ctrlState_t;

  function automatic logic [1:0] nextSlot(input logic [1:0] s);
    return (s == 2'd2) ? 2'd0 : s + 2'd1;
  endfunction

endpackage

// File: rtl/stereo_win_ctrl.sv
module stereo_win_ctrl
  import stereo_win_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int DISP  = 20,
  parameter int XW    = $clog2(IMG_W),
  parameter int YW    = $clog2(IMG_H),
  parameter int DW    = (DISP > 1) ? $clog2(DISP) : 1,
  parameter int RW    = $clog2(IMG_W + DISP + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output winStrobe_t    strb,
  output logic [XW-1:0] wrCol,
  output logic [RW-1:0] rdCol,
  output logic          winValid,
  output logic          sweepFirst,
  output logic          sweepLast,
  output logic          candInRange,
  output logic [DW-1:0] offset,
  output logic [XW-1:0] centerCol,
  output logic [YW-1:0] centerRow
);

  localparam logic [XW-1:0] XLAST  = XW'(IMG_W - 1);
  localparam logic [XW-1:0] XCLAST = XW'(IMG_W - 2);
  localparam logic [YW-1:0] YLAST  = YW'(IMG_H - 1);
  localparam logic [DW-1:0] DLAST  = DW'(DISP - 1);

  ctrlState_t    state;
  logic [XW-1:0] wrColQ;
  logic [YW-1:0] rowIdx;
  logic [1:0]    wrSlotQ;
  logic [1:0]    botSlotQ;
  logic [XW-1:0] xc;
  logic [YW-1:0] cy;
  logic [1:0]    k;
  logic [DW-1:0] d;
  logic          accept;

  assign inReady = (state == ST_LOAD);
  assign accept  = inValid && inReady;

  always_comb begin
    strb.wrEn       = accept;
    strb.wrSlot     = wrSlotQ;
    strb.botSlot    = botSlotQ;
    strb.shiftRight = (state == ST_RELOAD) || ((state == ST_SWEEP) && (d != DLAST));
    strb.shiftLeft  = (state == ST_RELOAD) && ((xc == XW'(1)) || (k == 2'd2));
    if (state == ST_RELOAD)
      rdCol = RW'(xc) + RW'(k) - RW'(1);
    else
      rdCol = RW'(xc) + RW'(d) + RW'(2);
  end

  assign wrCol       = wrColQ;
  assign winValid    = (state == ST_SWEEP);
  assign sweepFirst  = winValid && (d == '0);
  assign sweepLast   = winValid && (d == DLAST);
  assign candInRange = (RW'(xc) + RW'(d) + RW'(1)) <= RW'(IMG_W - 1);
  assign offset      = d;
  assign centerCol   = xc;
  assign centerRow   = cy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      wrColQ   <= '0;
      rowIdx   <= '0;
      wrSlotQ  <= '0;
      botSlotQ <= '0;
      xc       <= XW'(1);
      cy       <= '0;
      k        <= '0;
      d        <= '0;
    end else begin
      unique case (state)
        ST_LOAD: if (accept) begin
          if (wrColQ == XLAST) begin
            wrColQ  <= '0;
            wrSlotQ <= nextSlot(wrSlotQ);
            rowIdx  <= (rowIdx == YLAST) ? '0 : rowIdx + YW'(1);
            if (rowIdx >= YW'(2)) begin
              botSlotQ <= wrSlotQ;
              cy       <= rowIdx - YW'(1);
              xc       <= XW'(1);
              k        <= '0;
              state    <= ST_RELOAD;
            end
          end else begin
            wrColQ <= wrColQ + XW'(1);
          end
        end
        ST_RELOAD: begin
          k <= k + 2'd1;
          if (k == 2'd2) begin
            d     <= '0;
            state <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (d == DLAST) begin
            if (xc == XCLAST) begin
              state <= ST_LOAD;
            end else begin
              xc    <= xc + XW'(1);
              k     <= '0;
              state <= ST_RELOAD;
            end
          end else begin
            d <= d + DW'(1);
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // R6: offsets step by one on consecutive clocks inside a sweep
  assert_offset_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !sweepLast) |=> (winValid && (offset == $past(offset) + DW'(1))));

  // R6: every sweep opens at offset 0
  assert_sweep_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(winValid) |-> sweepFirst);

  // R8: a refill or a row load always follows the last offset
  assert_refill_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    sweepLast |=> !winValid);

  // R7: once a candidate leaves the image it stays out for the rest of the sweep
  assert_range_monotone_R7: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !sweepFirst && candInRange) |-> $past(candInRange));

  // R3: centre column stays inside the interior
  assert_center_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> ((centerCol >= XW'(1)) && (centerCol <= XCLAST)));

endmodule

// File: rtl/stereo_win_datapath.sv
module stereo_win_datapath
  import stereo_win_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int PIX_W = 8,
  parameter int XW    = $clog2(IMG_W),
  parameter int RW    = $clog2(IMG_W + 22)
) (
  input  logic               clk,
  input  logic               rstN,
  input  winStrobe_t         strb,
  input  logic [XW-1:0]      wrCol,
  input  logic [RW-1:0]      rdCol,
  input  logic [PIX_W-1:0]   inLeft,
  input  logic [PIX_W-1:0]   inRight,
  output logic [9*PIX_W-1:0] leftWin,
  output logic [9*PIX_W-1:0] rightWin
);

  logic [PIX_W-1:0] rowMemL [3][IMG_W];
  logic [PIX_W-1:0] rowMemR [3][IMG_W];
  logic [PIX_W-1:0] lw [3][3];
  logic [PIX_W-1:0] rw [3][3];
  logic [PIX_W-1:0] newColL [3];
  logic [PIX_W-1:0] newColR [3];
  logic [1:0]       rdSlot [3];
  logic             colOk;
  logic [XW-1:0]    rdIdx;

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      rowMemL[strb.wrSlot][wrCol] <= inLeft;
      rowMemR[strb.wrSlot][wrCol] <= inRight;
    end
  end

  assign rdSlot[2] = strb.botSlot;
  assign rdSlot[0] = nextSlot(strb.botSlot);
  assign rdSlot[1] = nextSlot(rdSlot[0]);
  assign colOk     = rdCol < RW'(IMG_W);
  assign rdIdx     = rdCol[XW-1:0];

  for (genvar r = 0; r < 3; r++) begin : g_rowRead
    assign newColL[r] = colOk ? rowMemL[rdSlot[r]][rdIdx] : '0;
    assign newColR[r] = colOk ? rowMemR[rdSlot[r]][rdIdx] : '0;
    for (genvar c = 0; c < 3; c++) begin : g_flat
      assign leftWin[(3*r+c)*PIX_W +: PIX_W]  = lw[r][c];
      assign rightWin[(3*r+c)*PIX_W +: PIX_W] = rw[r][c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) begin
          lw[r][c] <= '0;
          rw[r][c] <= '0;
        end
    end else begin
      for (int r = 0; r < 3; r++) begin
        if (strb.shiftRight) begin
          rw[r][0] <= rw[r][1];
          rw[r][1] <= rw[r][2];
          rw[r][2] <= newColR[r];
        end
        if (strb.shiftLeft) begin
          lw[r][0] <= lw[r][1];
          lw[r][1] <= lw[r][2];
          lw[r][2] <= newColL[r];
        end
      end
    end
  end

  // R5: a right-window shift moves each column one place toward the left edge
  assert_right_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftRight |=> (rw[1][1] == $past(rw[1][2])));

  // R4: the reference window holds still when no left shift is requested
  assert_left_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftLeft |=> (lw[1][1] == $past(lw[1][1])));

endmodule

// File: rtl/stereo_window_buffer.sv
module stereo_window_buffer
  import stereo_win_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int PIX_W = 8,
  parameter int DISP  = 20,
  localparam int XW   = $clog2(IMG_W),
  localparam int YW   = $clog2(IMG_H),
  localparam int DW   = (DISP > 1) ? $clog2(DISP) : 1,
  localparam int RW   = $clog2(IMG_W + DISP + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [PIX_W-1:0]   inLeft,
  input  logic [PIX_W-1:0]   inRight,
  output logic               winValid,
  output logic               sweepFirst,
  output logic               sweepLast,
  output logic               candInRange,
  output logic [DW-1:0]      offset,
  output logic [XW-1:0]      centerCol,
  output logic [YW-1:0]      centerRow,
  output logic [9*PIX_W-1:0] leftWin,
  output logic [9*PIX_W-1:0] rightWin
);

  winStrobe_t    strb;
  logic [XW-1:0] wrCol;
  logic [RW-1:0] rdCol;

  stereo_win_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .DISP(DISP),
    .XW(XW), .YW(YW), .DW(DW), .RW(RW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .strb(strb), .wrCol(wrCol), .rdCol(rdCol),
    .winValid(winValid), .sweepFirst(sweepFirst), .sweepLast(sweepLast),
    .candInRange(candInRange), .offset(offset),
    .centerCol(centerCol), .centerRow(centerRow)
  );

  stereo_win_datapath #(
    .IMG_W(IMG_W), .PIX_W(PIX_W), .XW(XW), .RW(RW)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrCol(wrCol), .rdCol(rdCol),
    .inLeft(inLeft), .inRight(inRight),
    .leftWin(leftWin), .rightWin(rightWin)
  );

endmodule

// File: tb/tb_stereo_window_buffer.sv
module tb_stereo_window_buffer;

  localparam int W  = 8;
  localparam int H  = 5;
  localparam int PW = 8;
  localparam int D  = 4;
  localparam int FRAMES = 2;

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0;
  logic [PW-1:0] inLeft = '0, inRight = '0;
  logic inReady, winValid, sweepFirst, sweepLast, candInRange;
  logic [1:0] offset;
  logic [2:0] centerCol;
  logic [2:0] centerRow;
  logic [9*PW-1:0] leftWin, rightWin;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  stereo_window_buffer #(.IMG_W(W), .IMG_H(H), .PIX_W(PW), .DISP(D)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inLeft(inLeft), .inRight(inRight), .winValid(winValid),
    .sweepFirst(sweepFirst), .sweepLast(sweepLast), .candInRange(candInRange),
    .offset(offset), .centerCol(centerCol), .centerRow(centerRow),
    .leftWin(leftWin), .rightWin(rightWin)
  );

  function automatic logic [PW-1:0] pixL(int x, int y, int f);
    return PW'(x * 7 + y * 13 + f * 31 + 1);
  endfunction
  function automatic logic [PW-1:0] pixR(int x, int y, int f);
    return PW'(x * 11 + y * 5 + f * 17 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [9*PW-1:0] act, input logic [9*PW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // stimulus: two frames in raster order with source-side gaps
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    check(inReady == 1'b1, "R1", "inReady after reset", 72'(inReady), 72'(1));
    check(winValid == 1'b0 && sweepFirst == 1'b0 && sweepLast == 1'b0,
          "R1", "window flags after reset", 72'({winValid, sweepFirst, sweepLast}), 72'(0));
    for (int f = 0; f < FRAMES; f++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) begin
          if ((x + y) % 4 == 2) begin
            inValid = 0;
            @(negedge clk);
          end
          while (!inReady) begin
            inValid = 0;
            @(negedge clk);
          end
          inValid = 1;
          inLeft  = pixL(x, y, f);
          inRight = pixR(x, y, f);
          @(negedge clk);
        end
    inValid = 0;
    wait (done);
    @(negedge clk);
    summary();
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !ended) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  // expected-sequence monitor
  int ef = 0, ey = 1, ex = 1, ed = 0;
  int lastEnd = 0;
  logic [9*PW-1:0] expL, expR;

  always @(negedge clk) begin
    if (rstN && !done && winValid) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++) begin
          int rc;
          expL[(3*r+c)*PW +: PW] = pixL(ex - 1 + c, ey - 1 + r, ef);
          rc = ex + ed - 1 + c;
          expR[(3*r+c)*PW +: PW] = (rc < W) ? pixR(rc, ey - 1 + r, ef) : '0;
        end
      // R2: no input accepted while windows are presented
      check(inReady == 1'b0, "R2", "inReady during sweep", 72'(inReady), 72'(0));
      // R3 and R9: centre position order across rows and frames
      check(centerRow == 3'(ey) && centerCol == 3'(ex), "R3", "centre position",
            72'({centerRow, centerCol}), 72'({3'(ey), 3'(ex)}));
      // R4: reference window contents
      check(leftWin == expL, "R4", "left window", leftWin, expL);
      // R5: candidate window contents, zero past the right edge
      check(rightWin == expR, "R5", "right window", rightWin, expR);
      // R6: offset and sweep markers
      check(offset == 2'(ed) && sweepFirst == (ed == 0) && sweepLast == (ed == D - 1),
            "R6", "offset/first/last", 72'({offset, sweepFirst, sweepLast}),
            72'({2'(ed), ed == 0, ed == D - 1}));
      // R7: in-range flag
      check(candInRange == (ex + ed + 1 <= W - 1), "R7", "candInRange",
            72'(candInRange), 72'(ex + ed + 1 <= W - 1));
      // R8: three idle clocks between sweeps of one row
      if (ed == 0 && ex > 1)
        check(cyc - lastEnd == 4, "R8", "refill gap", 72'(cyc - lastEnd), 72'(4));
      if (ed == D - 1) lastEnd = cyc;
      ed++;
      if (ed == D) begin
        ed = 0; ex++;
        if (ex == W - 1) begin
          ex = 1; ey++;
          if (ey == H - 1) begin
            ey = 1; ef++;
            if (ef == FRAMES) done = 1;
          end
        end
      end
    end
  end

endmodule